// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles conditional branches while they sit in the decode stage of a five-stage in-order pipeline. It owns the fetch program counter and the fetch/decode pipeline register. When the word in decode carries one of the two conditional-branch opcodes, a dedicated equality comparator checks the two source operands. In the same cycle the block asserts a redirect and presents the target, so the program counter loads the target on the next edge. The branch then travels down the rest of the pipeline as an idle operation.

A mode input picks how the word fetched behind a taken branch is treated. In squash mode, fetch runs sequentially as if no branch were taken, and a taken branch turns the fetched word into a bubble. That costs one lost slot. In delay-slot mode, that word always goes on into decode as a valid instruction. The comparator operands come from the register file. A forwarding override can replace either operand with a value produced later in the pipeline. When an operand is not ready yet, a hold input freezes fetch and decode.

Top module: `branch_resolve_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state has `pc_out` = 0, `id_valid` = 0, `id_word` = 0 and `id_link` = 0, and `redirect` stays low.
- R2: With no hold and no redirect, `pc_out` advances by 4 on each edge. On that edge decode captures `fetch_word` with `id_valid` = 1, and `id_link` is set to the fetch address plus 4.
- R3: A valid decode word whose opcode (bits 31:26) is 6'b000100 raises `redirect` in the same cycle when the two compared operands are equal.
- R4: A valid decode word whose opcode is 6'b000101 raises `redirect` in the same cycle when the two compared operands differ.
- R5: `redirect_pc` equals `id_link` plus the sign-extended 16-bit immediate (bits 15:0) shifted left by two. On a redirect, `pc_out` takes that value on the next edge.
- R6: When `delay_slot_mode` = 0 and a redirect occurs, `slot_kill` is high. On the next edge decode holds a bubble (`id_word` = 0, `id_valid` = 0, `id_link` = 0). A branch that is not taken leaves the following word intact.
- R7: When `delay_slot_mode` = 1, the word fetched after a branch enters decode valid, whether or not the branch is taken.
- R8: While `hold_fetch` is high, `pc_out` and the decode register keep their values and `redirect` stays low. The branch is resolved once the hold drops.
- R9: When `fwd_a_en` or `fwd_b_en` is high, the comparator uses `fwd_a_val` or `fwd_b_val` in place of the register-file value of that operand.
- R10: A decode word with any other opcode, or an invalid decode slot, never raises `redirect`, even when the operands are equal.
- R11: Equality covers all 32 bits: operands that differ only in bit 31 compare unequal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| delay_slot_mode | input | 1 | 1: delay slot always runs; 0: squash on taken branch |
| hold_fetch | input | 1 | Operand not ready; freeze PC and decode register |
| fetch_word | input | 32 | Instruction read at `pc_out` |
| rf_a | input | 32 | First source operand from the register file |
| rf_b | input | 32 | Second source operand from the register file |
| fwd_a_en | input | 1 | Use the forwarded value for the first operand |
| fwd_a_val | input | 32 | Forwarded value for the first operand |
| fwd_b_en | input | 1 | Use the forwarded value for the second operand |
| fwd_b_val | input | 32 | Forwarded value for the second operand |
| pc_out | output | 32 | Current fetch address |
| id_word | output | 32 | Instruction held in decode |
| id_link | output | 32 | Address after the decode instruction |
| id_valid | output | 1 | Decode slot holds a real instruction |
| redirect | output | 1 | Taken branch resolved this cycle |
| redirect_pc | output | 32 | Branch target for the decode word |
| slot_kill | output | 1 | Word being fetched is turned into a bubble |

## Verification
The bench runs straight-line code to fix the sequential baseline. It then sends both branch kinds with equal and unequal operands, so that taken and not-taken are told apart for each opcode. Positive and negative immediates confirm the sign extension of the target. Bit-31-only differences and forwarded operands that reverse an outcome show that the comparator sees the full, overridden operand. Holds over a pending branch, non-branch words with equal operands, and the same branches repeated in delay-slot mode separate the hold, decode and slot-treatment paths from one another.

// File: rtl/brp_pkg.sv
// Shared constants and helpers for the decode-stage branch resolver.
// Assumes a 32-bit word with the opcode in the top six bits.
package brp_pkg;
    localparam int WORD_W   = 32;
    localparam int OPC_W    = 6;
    localparam int IMM_W    = 16;
    localparam logic [OPC_W-1:0] OPC_BR_EQ = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_BR_NE = 6'b000101;

    typedef enum logic [1:0] {
        BR_NONE = 2'd0,
        BR_EQ   = 2'd1,
        BR_NE   = 2'd2
    } br_kind_e;

    // Classify an opcode into the branch kind it encodes.
    function automatic br_kind_e classify(input logic [OPC_W-1:0] opc);
        br_kind_e k;
        k = BR_NONE;
        if (opc == OPC_BR_EQ) k = BR_EQ;
        if (opc == OPC_BR_NE) k = BR_NE;
        return k;
    endfunction
endpackage

// File: rtl/brp_operand_mux.sv
// Selects the comparator operand: the forwarded value when the forward
// enable is set, otherwise the register-file value. Purely combinational.
module brp_operand_mux #(
    parameter int W = 32
) (
    input  logic         use_fwd,
    input  logic [W-1:0] rf_val,
    input  logic [W-1:0] fwd_val,
    output logic [W-1:0] opnd
);
    // Operand choice.
    always_comb begin
        opnd = use_fwd ? fwd_val : rf_val;
    end
endmodule

// File: rtl/brp_eq_compare.sv
// Equality comparator built from a bitwise XOR and a NOR reduction.
// No carry chain, so depth is log2(W) gates after the XOR layer.
module brp_eq_compare #(
    parameter int W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic         same
);
    logic [W-1:0] diff_bits;

    // Per-bit mismatch then all-zero detect.
    always_comb begin
        diff_bits = lhs ^ rhs;
        same      = ~|diff_bits;
    end
endmodule

// File: rtl/brp_target_gen.sv
// Branch target adder: link address plus the sign-extended immediate
// scaled by four. Assumes IMM_W + 2 <= W.
module brp_target_gen #(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  logic [W-1:0]     link,
    input  logic [IMM_W-1:0] imm,
    output logic [W-1:0]     target
);
    localparam int EXT_W = W - IMM_W - 2;

    logic [W-1:0] offset;

    // Sign-extend, scale and add.
    always_comb begin
        offset = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
        target = link + offset;
    end
endmodule

// File: rtl/brp_fetch_regs.sv
// Fetch program counter and fetch/decode pipeline register.
// Assumes redirect and squash are never asserted together with hold.
// A squash forces a bubble into decode but never blocks the target load.
module brp_fetch_regs #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         take,
    input  logic         squash,
    input  logic [W-1:0] target,
    input  logic [W-1:0] fetch_word,
    output logic [W-1:0] pc,
    output logic [W-1:0] dec_word,
    output logic [W-1:0] dec_link,
    output logic         dec_valid
);
    localparam logic [W-1:0] STEP = W'(4);

    logic [W-1:0] seq_pc;

    // Sequential successor of the fetch address.
    always_comb begin
        seq_pc = pc + STEP;
    end

    // Program counter update: reset, hold, redirect or step.
    always_ff @(posedge clk) begin
        if (!rst_n)    pc <= '0;
        else if (hold) pc <= pc;
        else if (take) pc <= target;
        else           pc <= seq_pc;
    end

    // Decode register update: reset, hold, bubble or capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_word  <= '0;
            dec_link  <= '0;
            dec_valid <= 1'b0;
        end else if (hold) begin
            dec_word  <= dec_word;
            dec_link  <= dec_link;
            dec_valid <= dec_valid;
        end else if (squash) begin
            dec_word  <= '0;
            dec_link  <= '0;
            dec_valid <= 1'b0;
        end else begin
            dec_word  <= fetch_word;
            dec_link  <= seq_pc;
            dec_valid <= 1'b1;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (pc == '0) && !dec_valid && (dec_word == '0)); // R1
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !take) |=> (pc == $past(pc) + STEP)); // R2
    AST_TARGET_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !hold) |=> (pc == $past(target))); // R5
    AST_SQUASH_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (squash && !hold) |=> !dec_valid && (dec_word == '0)); // R6
    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(pc) && $stable(dec_word) && $stable(dec_valid)); // R8
endmodule

// File: rtl/branch_resolve_unit.sv
// Decode-stage branch resolver. Classifies the decode word, compares the
// (possibly forwarded) operands for equality, and redirects fetch on a
// taken branch. In squash mode the fetched slot word becomes a bubble;
// in delay-slot mode it proceeds. Assumes hold_fetch covers any operand
// that cannot yet be forwarded.
module branch_resolve_unit
    import brp_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int OPC_B = OPC_W,
    parameter int IMM_B = IMM_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         delay_slot_mode,
    input  logic         hold_fetch,
    input  logic [W-1:0] fetch_word,
    input  logic [W-1:0] rf_a,
    input  logic [W-1:0] rf_b,
    input  logic         fwd_a_en,
    input  logic [W-1:0] fwd_a_val,
    input  logic         fwd_b_en,
    input  logic [W-1:0] fwd_b_val,
    output logic [W-1:0] pc_out,
    output logic [W-1:0] id_word,
    output logic [W-1:0] id_link,
    output logic         id_valid,
    output logic         redirect,
    output logic [W-1:0] redirect_pc,
    output logic         slot_kill
);
    localparam int N_OPND = 2;

    logic [N_OPND-1:0]        sel_fwd;
    logic [N_OPND-1:0][W-1:0] src_rf;
    logic [N_OPND-1:0][W-1:0] src_fwd;
    logic [N_OPND-1:0][W-1:0] opnd;
    logic                     operands_equal;
    br_kind_e                 kind;
    logic [W-1:0]             target;
    logic                     take;

    // Gather operand sources into arrays for the mux generate.
    always_comb begin
        sel_fwd = {fwd_b_en, fwd_a_en};
        src_rf  = {rf_b, rf_a};
        src_fwd = {fwd_b_val, fwd_a_val};
    end

    for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
        brp_operand_mux #(.W(W)) u_mux (
            .use_fwd (sel_fwd[i]),
            .rf_val  (src_rf[i]),
            .fwd_val (src_fwd[i]),
            .opnd    (opnd[i])
        );
    end

    brp_eq_compare #(.W(W)) u_cmp (
        .lhs  (opnd[0]),
        .rhs  (opnd[1]),
        .same (operands_equal)
    );

    brp_target_gen #(.W(W), .IMM_W(IMM_B)) u_tgt (
        .link   (id_link),
        .imm    (id_word[IMM_B-1:0]),
        .target (target)
    );

    // Branch decision: valid decode word, branch opcode, condition met, no hold.
    always_comb begin
        kind = id_valid ? classify(id_word[W-1 -: OPC_B]) : BR_NONE;
        unique case (kind)
            BR_EQ:   take = operands_equal;
            BR_NE:   take = !operands_equal;
            default: take = 1'b0;
        endcase
        take = take && !hold_fetch;
    end

    // Drive the redirect interface and the slot squash.
    always_comb begin
        redirect    = take;
        redirect_pc = target;
        slot_kill   = take && !delay_slot_mode;
    end

    brp_fetch_regs #(.W(W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (hold_fetch),
        .take       (take),
        .squash     (slot_kill),
        .target     (target),
        .fetch_word (fetch_word),
        .pc         (pc_out),
        .dec_word   (id_word),
        .dec_link   (id_link),
        .dec_valid  (id_valid)
    );

    AST_REDIRECT_NEEDS_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> id_valid && ((id_word[W-1 -: OPC_B] == OPC_BR_EQ) ||
                                  (id_word[W-1 -: OPC_B] == OPC_BR_NE))); // R10
    AST_DELAY_SLOT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && delay_slot_mode) |=> id_valid); // R7
    AST_NO_REDIRECT_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hold_fetch |-> !redirect && !slot_kill); // R8
endmodule

// File: tb/tb_branch_resolve_unit.sv
module tb_branch_resolve_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        delay_slot_mode = 1'b0;
    logic        hold_fetch = 1'b0;
    logic [31:0] fetch_word = '0;
    logic [31:0] rf_a = '0, rf_b = '0;
    logic        fwd_a_en = 1'b0, fwd_b_en = 1'b0;
    logic [31:0] fwd_a_val = '0, fwd_b_val = '0;
    logic [31:0] pc_out, id_word, id_link, redirect_pc;
    logic        id_valid, redirect, slot_kill;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    branch_resolve_unit dut (
        .clk(clk), .rst_n(rst_n), .delay_slot_mode(delay_slot_mode),
        .hold_fetch(hold_fetch), .fetch_word(fetch_word),
        .rf_a(rf_a), .rf_b(rf_b), .fwd_a_en(fwd_a_en), .fwd_a_val(fwd_a_val),
        .fwd_b_en(fwd_b_en), .fwd_b_val(fwd_b_val),
        .pc_out(pc_out), .id_word(id_word), .id_link(id_link), .id_valid(id_valid),
        .redirect(redirect), .redirect_pc(redirect_pc), .slot_kill(slot_kill)
    );

    typedef struct {
        logic [31:0] pc;
        logic [31:0] word;
        logic [31:0] link;
        logic        valid;
        string       tag;
    } exp_t;

    exp_t sb[$];

    // Reference state derived from the requirements.
    logic [31:0] m_pc = '0, m_word = '0, m_link = '0;
    logic        m_valid = 1'b0;

    function automatic logic [31:0] mk_br(input logic ne, input logic [15:0] imm);
        return {ne ? 6'b000101 : 6'b000100, 5'd1, 5'd2, imm};
    endfunction

    function automatic logic [31:0] mk_alu(input logic [15:0] imm);
        return {6'b001000, 5'd3, 5'd4, imm};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus, check same-cycle outputs,
    // and queue the expected registered state for the monitor.
    task automatic step(input logic [31:0] fw, input logic [31:0] a, input logic [31:0] b,
                        input logic fa, input logic [31:0] fav,
                        input logic fb, input logic [31:0] fbv,
                        input logic hold, input logic rst_v, input string tag);
        logic [31:0] oa, ob, tgt;
        logic        is_eq, is_ne, tk;
        exp_t e;
        @(negedge clk);
        fetch_word = fw; rf_a = a; rf_b = b;
        fwd_a_en = fa; fwd_a_val = fav; fwd_b_en = fb; fwd_b_val = fbv;
        hold_fetch = hold; rst_n = rst_v;
        #1;
        oa = fa ? fav : a;
        ob = fb ? fbv : b;
        is_eq = m_valid && (m_word[31:26] == 6'b000100);
        is_ne = m_valid && (m_word[31:26] == 6'b000101);
        tk = !hold && ((is_eq && (oa == ob)) || (is_ne && (oa != ob)));
        tgt = m_link + {{14{m_word[15]}}, m_word[15:0], 2'b00};
        check({tag, " redirect"}, {31'd0, redirect}, {31'd0, tk});
        check({tag, " slot_kill"}, {31'd0, slot_kill}, {31'd0, tk && !delay_slot_mode});
        if (m_valid && (is_eq || is_ne))
            check({tag, " target R5"}, redirect_pc, tgt);
        if (!rst_v) begin
            m_pc = '0; m_word = '0; m_link = '0; m_valid = 1'b0;
        end else if (!hold) begin
            if (tk && !delay_slot_mode) begin
                m_word = '0; m_link = '0; m_valid = 1'b0;
            end else begin
                m_word = fw; m_link = m_pc + 4; m_valid = 1'b1;
            end
            m_pc = tk ? tgt : m_pc + 4;
        end
        e.pc = m_pc; e.word = m_word; e.link = m_link; e.valid = m_valid; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: after each edge, compare registered state with the queue head.
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " pc"}, pc_out, e.pc);
                check({e.tag, " id_word"}, id_word, e.word);
                check({e.tag, " id_link"}, id_link, e.link);
                check({e.tag, " id_valid"}, {31'd0, id_valid}, {31'd0, e.valid});
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 20000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(mk_alu(16'd1), 0, 0, 0, 0, 0, 0, 0, 0, "R1 reset");
        step(mk_alu(16'd1), 0, 0, 0, 0, 0, 0, 0, 0, "R1 reset");
        // R2 straight-line fetch
        step(mk_alu(16'd2), 0, 0, 0, 0, 0, 0, 0, 1, "R2 seq");
        step(mk_alu(16'd3), 0, 0, 0, 0, 0, 0, 0, 1, "R2 seq");
        step(mk_alu(16'd4), 0, 0, 0, 0, 0, 0, 0, 1, "R2 seq");
        // R3 equal-branch taken, squash mode R6
        step(mk_br(0, 16'd3), 0, 0, 0, 0, 0, 0, 0, 1, "R3 fetch");
        step(mk_alu(16'h55), 7, 7, 0, 0, 0, 0, 0, 1, "R3 R6 taken squash");
        step(mk_alu(16'h66), 0, 1, 0, 0, 0, 0, 0, 1, "R6 bubble in decode");
        // R3 equal-branch not taken
        step(mk_br(0, 16'd5), 0, 1, 0, 0, 0, 0, 0, 1, "R3 fetch");
        step(mk_alu(16'h77), 3, 4, 0, 0, 0, 0, 0, 1, "R3 R6 not taken keeps slot");
        // R4 not-equal branch, equal operands: not taken
        step(mk_br(1, 16'd8), 0, 1, 0, 0, 0, 0, 0, 1, "R4 fetch");
        step(mk_alu(16'h88), 9, 9, 0, 0, 0, 0, 0, 1, "R4 not taken");
        // R4 not-equal branch taken, negative immediate R5
        step(mk_br(1, 16'hFFFC), 0, 0, 0, 0, 0, 0, 0, 1, "R4 fetch");
        step(mk_alu(16'h99), 1, 2, 0, 0, 0, 0, 0, 1, "R4 R5 taken backward");
        step(mk_alu(16'h9A), 0, 0, 0, 0, 0, 0, 0, 1, "R5 after backward");
        // R8 hold over a pending branch
        step(mk_br(0, 16'd2), 0, 1, 0, 0, 0, 0, 0, 1, "R8 fetch");
        step(mk_alu(16'hA1), 5, 5, 0, 0, 0, 0, 1, 1, "R8 hold");
        step(mk_alu(16'hA2), 5, 5, 0, 0, 0, 0, 1, 1, "R8 hold");
        step(mk_alu(16'hA3), 5, 5, 0, 0, 0, 0, 0, 1, "R8 release resolves");
        // R9 forwarding reverses the outcome
        step(mk_br(0, 16'd4), 0, 1, 0, 0, 0, 0, 0, 1, "R9 fetch");
        step(mk_alu(16'hB1), 1, 2, 1, 2, 0, 0, 0, 1, "R9 fwd a makes equal");
        step(mk_br(1, 16'd4), 0, 1, 0, 0, 0, 0, 0, 1, "R9 fetch");
        step(mk_alu(16'hB2), 1, 2, 0, 0, 1, 1, 0, 1, "R9 fwd b makes equal");
        // R11 bit-31-only difference
        step(mk_br(0, 16'd6), 0, 1, 0, 0, 0, 0, 0, 1, "R11 fetch");
        step(mk_alu(16'hC1), 32'h8000_0000, 0, 0, 0, 0, 0, 0, 1, "R11 msb differs");
        // R10 non-branch with equal operands
        step(mk_alu(16'd3), 0, 1, 0, 0, 0, 0, 0, 1, "R10 fetch");
        step(mk_alu(16'hD1), 4, 4, 0, 0, 0, 0, 0, 1, "R10 no redirect");
        // R7 delay-slot mode
        delay_slot_mode = 1'b1;
        step(mk_br(0, 16'd3), 0, 1, 0, 0, 0, 0, 0, 1, "R7 fetch");
        step(mk_alu(16'hE1), 6, 6, 0, 0, 0, 0, 0, 1, "R7 taken slot kept");
        step(mk_alu(16'hE2), 0, 1, 0, 0, 0, 0, 0, 1, "R7 slot in decode");
        step(mk_br(1, 16'd2), 0, 1, 0, 0, 0, 0, 0, 1, "R7 fetch");
        step(mk_alu(16'hE3), 6, 6, 0, 0, 0, 0, 0, 1, "R7 not taken slot kept");
        step(mk_alu(16'hE4), 0, 1, 0, 0, 0, 0, 0, 1, "R7 after");
        // R1 reset mid-run
        step(mk_alu(16'hF1), 0, 1, 0, 0, 0, 0, 0, 0, "R1 reset again");
        step(mk_alu(16'hF2), 0, 1, 0, 0, 0, 0, 0, 1, "R2 restart");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule